// File: doc/BRIEF.md
# Six-State Counter with Selectable Feedback Schemes

The block wraps a four-bit synchronous binary up counter, which has a synchronous clear, a parallel load, a count enable and a carry-out. Feedback logic closes the loop four different ways so that the counter repeats a sequence of six states. Two schemes run 0 to 5. One clears the register on state 5 and the other loads zero on state 5. A third loads 10 when carry-out is high, so it runs 10 to 15. The fourth loads 3 on state 8, so it runs 3 to 8.

A two-bit mode input picks the scheme. The scheme in force is captured at reset and again at each restart of the sequence, so a change of mode never cuts a sequence short. The block drives the count, the carry-out, and a four-bit wrap vector. One bit of that vector, the bit for the active scheme, is high during the cycle whose clock edge restarts the sequence.

Top module: `sixstate_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the count becomes the first state of the scheme on `mode` and that scheme becomes active. The mode encodings are 0 = clear on 5, 1 = load zero on 5, 2 = load 10 on carry, 3 = load 3 on 8. The first states are 0, 0, 10 and 3.
- R2: While `en` is low and `rst` is low, the count holds its value across edges and `wrap` is 0000.
- R3: While `en` is high and the count is not the active scheme's last state, each edge adds one to the count.
- R4: Under scheme 0 the count cycles 0,1,2,3,4,5 and returns to 0 through the clear path.
- R5: Under scheme 1 the count cycles 0,1,2,3,4,5 and returns to 0 through the load path with zero data.
- R6: Under scheme 2 the count cycles 10 through 15, and the carry-out at 15 loads 10.
- R7: Under scheme 3 the count cycles 3 through 8, and state 8 loads 3.
- R8: `carry` is 1 exactly when the count is 1111, in every scheme.
- R9: `wrap` bit k is high, and every other bit is low, in a cycle where scheme k is active, `en` is high and the count is that scheme's last state (5, 5, 15, 8). In all other cycles `wrap` is 0000.
- R10: A new value on `mode` leaves the current sequence untouched until the next restart. At that edge the count becomes the new scheme's first state, and the new scheme becomes active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Active-high synchronous reset to the first state of `mode` |
| en | input | 1 | Count enable |
| mode | input | 2 | Scheme select, applied at reset or at restart |
| count | output | 4 | Current counter value |
| carry | output | 1 | High when the count is all ones |
| wrap | output | 4 | One-hot restart flag, bit index = active scheme |

## Verification
The bench goes after the restart edge of each scheme. A design with an off-by-one decode would show a seventh state, or stop the sequence one state early, and the reference sequence catches either fault at once. Enable is also dropped while the count sits on a terminal state. A design that let the feedback fire without the enable would jump to the first state and raise `wrap`. Last, the mode is changed in the middle of a sequence. A design that switched schemes at once would leave the old range early, and one that never captured the new mode would keep repeating the old range.

// File: rtl/sixstate_pkg.sv
package sixstate_pkg;

  localparam int CW = 4;
  localparam int NSCH = 4;
  localparam int SW = $clog2(NSCH);

  typedef logic [CW-1:0] cnt_t;

  typedef enum logic [SW-1:0] {
    SCH_CLR5  = 2'd0,
    SCH_LD5   = 2'd1,
    SCH_CARRY = 2'd2,
    SCH_LD8   = 2'd3
  } scheme_e;

  localparam cnt_t ALL_ONES    = {CW{1'b1}};
  localparam cnt_t PRESET_HIGH = cnt_t'(10);
  localparam cnt_t PRESET_LOW  = cnt_t'(3);
  localparam cnt_t TERM_FIVE   = cnt_t'(5);
  localparam cnt_t TERM_EIGHT  = cnt_t'(8);

  // Value the sequence restarts from under a scheme.
  function automatic cnt_t first_state(scheme_e s);
    cnt_t v;
    case (s)
      SCH_CLR5:  v = '0;
      SCH_LD5:   v = '0;
      SCH_CARRY: v = PRESET_HIGH;
      SCH_LD8:   v = PRESET_LOW;
      default:   v = '0;
    endcase
    return v;
  endfunction

  // Value whose detection triggers the restart.
  function automatic cnt_t last_state(scheme_e s);
    cnt_t v;
    case (s)
      SCH_CLR5:  v = TERM_FIVE;
      SCH_LD5:   v = TERM_FIVE;
      SCH_CARRY: v = ALL_ONES;
      SCH_LD8:   v = TERM_EIGHT;
      default:   v = TERM_FIVE;
    endcase
    return v;
  endfunction

  // The restart goes through the clear path for this scheme, not the load path.
  function automatic logic restart_by_clear(scheme_e s);
    return (s == SCH_CLR5);
  endfunction

  // A scheme that detects its terminal state from the carry-out.
  function automatic logic detect_by_carry(scheme_e s);
    return (s == SCH_CARRY);
  endfunction

endpackage

// File: rtl/upcnt_core.sv
module upcnt_core #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         ld,
  input  logic         cnt,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         co
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] q_r;
  logic [W-1:0] q_inc;

  assign q_inc = q_r + W'(1);

  // Clear beats load, and load beats count.
  always_ff @(posedge clk) begin
    if (!clr_n)   q_r <= '0;
    else if (ld)  q_r <= din;
    else if (cnt) q_r <= q_inc;
  end

  assign q  = q_r;
  assign co = (q_r == TOP);

endmodule

// File: rtl/term_decode.sv
module term_decode
  import sixstate_pkg::*;
(
  input  cnt_t            q,
  input  logic            co,
  input  logic            en,
  input  scheme_e         act,
  output logic            fire,
  output logic [NSCH-1:0] wrap
);

  logic [NSCH-1:0] hit;

  for (genvar k = 0; k < NSCH; k++) begin : g_hit
    localparam scheme_e SK = scheme_e'(k);
    if (detect_by_carry(SK)) begin : g_carry
      assign hit[k] = co;
    end else begin : g_value
      assign hit[k] = (q == last_state(SK));
    end
    assign wrap[k] = fire && (act == SK);
  end

  assign fire = en && hit[act];

endmodule

// File: rtl/restart_sel.sv
module restart_sel
  import sixstate_pkg::*;
(
  input  logic    rst,
  input  logic    fire,
  input  scheme_e next_sch,
  output logic    restart,
  output logic    clr_n,
  output logic    ld,
  output cnt_t    din
);

  assign restart = rst || fire;

  always_comb begin
    clr_n = 1'b1;
    ld    = 1'b0;
    din   = first_state(next_sch);
    if (restart) begin
      if (restart_by_clear(next_sch)) clr_n = 1'b0;
      else                            ld    = 1'b1;
    end
  end

endmodule

// File: rtl/sixstate_counter.sv
module sixstate_counter
  import sixstate_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [1:0] mode,
  output logic [3:0] count,
  output logic       carry,
  output logic [3:0] wrap
);

  scheme_e act_q;
  scheme_e mode_s;
  logic    fire;
  logic    restart;
  logic    clr_n;
  logic    ld;
  cnt_t    din;
  cnt_t    q;
  logic    co;
  logic [NSCH-1:0] wrap_s;

  assign mode_s = scheme_e'(mode);

  always_ff @(posedge clk) begin
    if (restart) act_q <= mode_s;
  end

  upcnt_core #(.W(CW)) u_core (
    .clk   (clk),
    .clr_n (clr_n),
    .ld    (ld),
    .cnt   (en),
    .din   (din),
    .q     (q),
    .co    (co)
  );

  term_decode u_dec (
    .q    (q),
    .co   (co),
    .en   (en),
    .act  (act_q),
    .fire (fire),
    .wrap (wrap_s)
  );

  restart_sel u_sel (
    .rst      (rst),
    .fire     (fire),
    .next_sch (mode_s),
    .restart  (restart),
    .clr_n    (clr_n),
    .ld       (ld),
    .din      (din)
  );

  assign count = q;
  assign carry = co;
  assign wrap  = wrap_s;

  // R1
  reset_first_chk: assert property (@(posedge clk)
    rst |=> (count == first_state(scheme_e'($past(mode)))));

  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(count));

  // R3
  step_one_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !fire) |=> (count == $past(count) + 4'd1));

  // R6
  carry_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (en && carry && act_q == SCH_CARRY && mode_s == SCH_CARRY) |=> (count == PRESET_HIGH));

  // R9
  wrap_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wrap) && (en || wrap == '0));

  // R10
  restart_target_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> (count == first_state(scheme_e'($past(mode)))));

  // R4
  in_range_chk: assert property (@(posedge clk) disable iff (rst)
    (count >= first_state(act_q)) && (count <= last_state(act_q)));

endmodule

// File: tb/sixstate_counter_tb_top.sv
module sixstate_counter_tb_top;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [3:0] cnt;
    logic       cy;
    logic [3:0] wr;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [3:0] count;
  logic       carry;
  logic [3:0] wrap;

  int total = 0;
  int bad = 0;
  exp_t sb[$];

  logic [3:0] m_cnt;
  logic [1:0] m_act;

  sixstate_counter dut_i (
    .clk(clk), .rst(rst), .en(en), .mode(mode),
    .count(count), .carry(carry), .wrap(wrap)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] ref_start(logic [1:0] m);
    return (m == 2'd2) ? 4'd10 : (m == 2'd3) ? 4'd3 : 4'd0;
  endfunction

  function automatic logic [3:0] ref_end(logic [1:0] m);
    return (m == 2'd2) ? 4'd15 : (m == 2'd3) ? 4'd8 : 4'd5;
  endfunction

  // Driver: apply inputs for one edge, advance the model, queue what follows.
  task automatic drive(input logic r, input logic e, input logic [1:0] m, input string tag);
    exp_t it;
    @(negedge clk);
    rst = r; en = e; mode = m;
    if (r || (e && m_cnt == ref_end(m_act))) begin
      m_cnt = ref_start(m);
      m_act = m;
    end else if (e) begin
      m_cnt = m_cnt + 4'd1;
    end
    it.cnt = m_cnt;
    it.cy  = (m_cnt == 4'hF);
    it.wr  = (e && !r && m_cnt == ref_end(m_act)) ? (4'b0001 << m_act) : 4'b0000;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic run(input int n, input logic e, input logic [1:0] m, input string tag);
    for (int i = 0; i < n; i++) drive(1'b0, e, m, tag);
  endtask

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Monitor: after each edge, compare the outputs with the oldest queued item.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t it;
        it = sb.pop_front();
        cmp(it.tag, "count", int'(count), int'(it.cnt));
        cmp("R8", "carry", int'(carry), int'(it.cy));
        cmp("R9", "wrap", int'(wrap), int'(it.wr));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_cnt = 4'd0;
    m_act = 2'd0;
    // R1 and R4: clear-on-5 scheme, including an enable pause mid-sequence (R2, R3)
    drive(1'b1, 1'b0, 2'd0, "R1");
    run(8, 1'b1, 2'd0, "R4");
    run(3, 1'b0, 2'd0, "R2");
    run(14, 1'b1, 2'd0, "R4");
    // R5: load-zero scheme
    drive(1'b1, 1'b0, 2'd1, "R1");
    run(20, 1'b1, 2'd1, "R5");
    // R6: carry-driven load of 10
    drive(1'b1, 1'b0, 2'd2, "R1");
    run(5, 1'b1, 2'd2, "R6");
    run(3, 1'b0, 2'd2, "R2");
    run(17, 1'b1, 2'd2, "R6");
    // R7: load 3 on state 8
    drive(1'b1, 1'b0, 2'd3, "R1");
    run(5, 1'b1, 2'd3, "R7");
    run(3, 1'b0, 2'd3, "R2");
    run(17, 1'b1, 2'd3, "R7");
    // R10: mode changed mid-sequence; switch happens at the restart
    drive(1'b1, 1'b0, 2'd3, "R1");
    run(2, 1'b1, 2'd3, "R3");
    run(20, 1'b1, 2'd2, "R10");
    run(3, 1'b1, 2'd0, "R10");
    run(20, 1'b1, 2'd1, "R10");
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule